// File: doc/BRIEF.md
# Dual Elevator Floor Controller

This block runs two independent elevator cars. Each car sits on one of nine floors, numbered 1 to 9. A single divider makes a one-cycle step pulse every half second from the system clock. On each pulse, each car that is not stopped moves one floor in the direction its direction input selects. A car stays put when it is already at the end of the shaft in the direction asked.

A master reset clears the divider and sends both cars to floor 2. Each car also has its own reset, which sends only that car to floor 2. It does not touch the divider or the other car.

One scanned four-digit seven-segment display shows both floors. Car A's floor is on digit 2, car B's floor is on digit 0, and digits 1 and 3 stay dark. A debug output toggles on every step pulse, so it blinks at the step rate. The binary floor of each car is also brought out.

Top module: `dual_lift_ctrl`

## Requirements
- R1: While the master reset is high and on the first cycle after it is released, both floor outputs read 2, the step indicator reads 0, and the digit enables read 4'b1110 (digit 0 driven).
- R2: Floors change only on step edges, and step edges come every TICK_CYCLES clock cycles. The step indicator inverts at each step edge and at no other time.
- R3: On a step edge, a car whose stop input is 0 and whose direction input is 1 moves up by exactly one floor when it is below floor 9.
- R4: On a step edge, a car whose stop input is 0 and whose direction input is 0 moves down by exactly one floor when it is above floor 1.
- R5: On a step edge, a car whose stop input is 1 keeps its floor.
- R6: A car on floor 9 with direction 1 stays on floor 9.
- R7: A car on floor 1 with direction 0 stays on floor 1.
- R8: A car's own reset returns that car to floor 2 on the next clock edge. It leaves the other car's floor and the step timing unchanged.
- R9: The master reset clears the divider. The first step edge after release comes TICK_CYCLES cycles after the release.
- R10: Segment outputs are active low in bit order {g,f,e,d,c,b,a}. When digit 2 is driven, they show car A's floor; when digit 0 is driven, car B's floor; when digit 1 or 3 is driven, all ones. The lit segments are: 1 = b,c; 2 = a,b,d,e,g; 3 = a,b,c,d,g; 4 = b,c,f,g; 5 = a,c,d,f,g; 6 = a,c,d,e,f,g; 7 = a,b,c; 8 = all; 9 = a,b,c,d,f,g.
- R11: Digit enables are active low, with exactly one bit low at any time. The scan runs through digits 0, 1, 2, 3 and back to 0, and holds each digit for SCAN_CYCLES cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Master reset, synchronous, active high |
| rst_a | input | 1 | Car A reset, synchronous, active high |
| rst_b | input | 1 | Car B reset, synchronous, active high |
| stop_a | input | 1 | Car A hold |
| dir_a | input | 1 | Car A direction, 1 = up |
| stop_b | input | 1 | Car B hold |
| dir_b | input | 1 | Car B direction, 1 = up |
| seg_n | output | 7 | Segments {g,f,e,d,c,b,a}, active low |
| an_n | output | 4 | Digit enables, active low |
| step_led | output | 1 | Toggles on each step pulse |
| floor_a | output | 4 | Car A floor, binary |
| floor_b | output | 4 | Car B floor, binary |

## Verification
Two situations are hard to reach from the ports. The first is a car reset that lands in the middle of a step interval. To reach it, the stimulus lines up on an observed toggle of the step indicator and then pulses the car reset a known number of cycles later. The next step must then arrive after the rest of the same interval, not after a full fresh one. The second is the ends of the shaft, where moving the car takes many step periods. The bench drives car A up past floor 9 and car B down past floor 1, and checks one extra step at each end.

// File: rtl/dual_lift_pkg.sv
package dual_lift_pkg;

   localparam int SEG_W = 7;
   localparam logic [SEG_W-1:0] SEG_BLANK_N = '1;

   // Floor code to active-low segments, bit order {g,f,e,d,c,b,a}
   function automatic logic [SEG_W-1:0] floor_to_seg_n(input logic [3:0] fl);
      logic [SEG_W-1:0] lit;
      case (fl)
         4'd1:    lit = 7'b0000110;
         4'd2:    lit = 7'b1011011;
         4'd3:    lit = 7'b1001111;
         4'd4:    lit = 7'b1100110;
         4'd5:    lit = 7'b1101101;
         4'd6:    lit = 7'b1111101;
         4'd7:    lit = 7'b0000111;
         4'd8:    lit = 7'b1111111;
         4'd9:    lit = 7'b1101111;
         default: lit = 7'b0000000;
      endcase
      return ~lit;
   endfunction

endpackage

// File: rtl/lift_step_gen.sv
module lift_step_gen #(
   parameter int TICK_CYCLES = 50_000_000
) (
   input  logic clk,
   input  logic rst,
   output logic step,
   output logic blink
);
   localparam int CNT_W = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TICK_CYCLES - 1);

   if (TICK_CYCLES < 2) begin : g_bad_tick
      $error("lift_step_gen: TICK_CYCLES must be at least 2");
   end

   logic [CNT_W-1:0] cnt;

   assign step = (cnt == CNT_LAST);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt   <= '0;
         blink <= 1'b0;
      end else begin
         cnt   <= step ? '0 : cnt + CNT_W'(1);
         blink <= blink ^ step;
      end
   end

   // R2
   cnt_range_chk: assert property (@(posedge clk) disable iff (rst) cnt <= CNT_LAST);
   // R2
   blink_quiet_chk: assert property (@(posedge clk) disable iff (rst) !step |=> $stable(blink));
   // R2
   blink_flip_chk: assert property (@(posedge clk) disable iff (rst) step |=> blink != $past(blink));

endmodule

// File: rtl/lift_floor_fsm.sv
module lift_floor_fsm #(
   parameter int FLOOR_W   = 4,
   parameter int FLOOR_MIN = 1,
   parameter int FLOOR_MAX = 9,
   parameter int FLOOR_RST = 2
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               step,
   input  logic               hold,
   input  logic               go_up,
   output logic [FLOOR_W-1:0] floor
);
   localparam logic [FLOOR_W-1:0] F_MIN = FLOOR_W'(FLOOR_MIN);
   localparam logic [FLOOR_W-1:0] F_MAX = FLOOR_W'(FLOOR_MAX);
   localparam logic [FLOOR_W-1:0] F_RST = FLOOR_W'(FLOOR_RST);

   if (FLOOR_MIN >= FLOOR_MAX || FLOOR_MAX >= (1 << FLOOR_W)) begin : g_bad_range
      $error("lift_floor_fsm: floor range does not fit FLOOR_W");
   end
   if (FLOOR_RST < FLOOR_MIN || FLOOR_RST > FLOOR_MAX) begin : g_bad_rst
      $error("lift_floor_fsm: reset floor outside range");
   end

   logic at_top, at_bot;
   assign at_top = (floor == F_MAX);
   assign at_bot = (floor == F_MIN);

   always_ff @(posedge clk) begin
      if (rst) begin
         floor <= F_RST;
      end else if (step && !hold) begin
         if (go_up && !at_top)       floor <= floor + FLOOR_W'(1);
         else if (!go_up && !at_bot) floor <= floor - FLOOR_W'(1);
      end
   end

   // R2
   floor_inrange_chk: assert property (@(posedge clk) disable iff (rst)
      floor >= F_MIN && floor <= F_MAX);
   // R2
   no_move_between_steps_chk: assert property (@(posedge clk) disable iff (rst)
      !step |=> $stable(floor));
   // R5
   hold_keeps_floor_chk: assert property (@(posedge clk) disable iff (rst)
      step && hold |=> $stable(floor));
   // R3
   up_one_chk: assert property (@(posedge clk) disable iff (rst)
      step && !hold && go_up && floor != F_MAX |=> floor == $past(floor) + FLOOR_W'(1));
   // R4
   down_one_chk: assert property (@(posedge clk) disable iff (rst)
      step && !hold && !go_up && floor != F_MIN |=> floor == $past(floor) - FLOOR_W'(1));
   // R6
   top_sat_chk: assert property (@(posedge clk) disable iff (rst)
      step && go_up && floor == F_MAX |=> floor == F_MAX);
   // R7
   bot_sat_chk: assert property (@(posedge clk) disable iff (rst)
      step && !go_up && floor == F_MIN |=> floor == F_MIN);

endmodule

// File: rtl/lift_scan_display.sv
module lift_scan_display
   import dual_lift_pkg::*;
#(
   parameter int NUM_DIGITS  = 4,
   parameter int SCAN_CYCLES = 100_000,
   parameter int DIGIT_A     = 2,
   parameter int DIGIT_B     = 0,
   parameter int FLOOR_W     = 4
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic [FLOOR_W-1:0]    floor_a,
   input  logic [FLOOR_W-1:0]    floor_b,
   output logic [SEG_W-1:0]      seg_n,
   output logic [NUM_DIGITS-1:0] an_n
);
   localparam int IDX_W = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1;
   localparam int DW_W  = (SCAN_CYCLES > 2) ? $clog2(SCAN_CYCLES) : 1;
   localparam logic [DW_W-1:0]  DW_LAST  = DW_W'(SCAN_CYCLES - 1);
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_DIGITS - 1);

   if (NUM_DIGITS < 2 || DIGIT_A >= NUM_DIGITS || DIGIT_B >= NUM_DIGITS || DIGIT_A == DIGIT_B)
   begin : g_bad_digits
      $error("lift_scan_display: digit assignment invalid");
   end
   if (SCAN_CYCLES < 2) begin : g_bad_scan
      $error("lift_scan_display: SCAN_CYCLES must be at least 2");
   end

   logic [DW_W-1:0]  dwell;
   logic [IDX_W-1:0] idx;
   logic [SEG_W-1:0] seg_by_digit [NUM_DIGITS];

   always_ff @(posedge clk) begin
      if (rst) begin
         dwell <= '0;
         idx   <= '0;
      end else if (dwell == DW_LAST) begin
         dwell <= '0;
         idx   <= (idx == IDX_LAST) ? '0 : idx + IDX_W'(1);
      end else begin
         dwell <= dwell + DW_W'(1);
      end
   end

   for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_digit
      if (d == DIGIT_A) begin : g_a
         assign seg_by_digit[d] = floor_to_seg_n(4'(floor_a));
      end else if (d == DIGIT_B) begin : g_b
         assign seg_by_digit[d] = floor_to_seg_n(4'(floor_b));
      end else begin : g_blank
         assign seg_by_digit[d] = SEG_BLANK_N;
      end
      assign an_n[d] = (idx != IDX_W'(d));
   end

   assign seg_n = seg_by_digit[idx];

   // R11
   one_digit_chk: assert property (@(posedge clk) disable iff (rst)
      $countones(~an_n) == 1);
   // R11
   scan_hold_chk: assert property (@(posedge clk) disable iff (rst)
      dwell != DW_LAST |=> $stable(an_n));
   // R10
   blank_digit_chk: assert property (@(posedge clk) disable iff (rst)
      an_n[1] == 1'b0 |-> seg_n == SEG_BLANK_N);

endmodule

// File: rtl/dual_lift_ctrl.sv
module dual_lift_ctrl
   import dual_lift_pkg::*;
#(
   parameter int CLK_HZ      = 100_000_000,
   parameter int STEP_MS     = 500,
   parameter int SCAN_HZ     = 1000,
   parameter int TICK_CYCLES = (CLK_HZ / 1000) * STEP_MS,
   parameter int SCAN_CYCLES = CLK_HZ / SCAN_HZ
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       rst_a,
   input  logic       rst_b,
   input  logic       stop_a,
   input  logic       dir_a,
   input  logic       stop_b,
   input  logic       dir_b,
   output logic [6:0] seg_n,
   output logic [3:0] an_n,
   output logic       step_led,
   output logic [3:0] floor_a,
   output logic [3:0] floor_b
);
   localparam int NUM_CARS = 2;
   localparam int FLOOR_W  = 4;

   logic               step;
   logic               car_rst  [NUM_CARS];
   logic               car_hold [NUM_CARS];
   logic               car_up   [NUM_CARS];
   logic [FLOOR_W-1:0] car_floor[NUM_CARS];

   assign car_rst[0]  = rst | rst_a;
   assign car_rst[1]  = rst | rst_b;
   assign car_hold[0] = stop_a;
   assign car_hold[1] = stop_b;
   assign car_up[0]   = dir_a;
   assign car_up[1]   = dir_b;

   lift_step_gen #(.TICK_CYCLES(TICK_CYCLES)) u_step (
      .clk   (clk),
      .rst   (rst),
      .step  (step),
      .blink (step_led)
   );

   for (genvar c = 0; c < NUM_CARS; c++) begin : g_car
      lift_floor_fsm #(
         .FLOOR_W   (FLOOR_W),
         .FLOOR_MIN (1),
         .FLOOR_MAX (9),
         .FLOOR_RST (2)
      ) u_fsm (
         .clk   (clk),
         .rst   (car_rst[c]),
         .step  (step),
         .hold  (car_hold[c]),
         .go_up (car_up[c]),
         .floor (car_floor[c])
      );
   end

   assign floor_a = car_floor[0];
   assign floor_b = car_floor[1];

   lift_scan_display #(
      .NUM_DIGITS  (4),
      .SCAN_CYCLES (SCAN_CYCLES),
      .DIGIT_A     (2),
      .DIGIT_B     (0),
      .FLOOR_W     (FLOOR_W)
   ) u_disp (
      .clk     (clk),
      .rst     (rst),
      .floor_a (car_floor[0]),
      .floor_b (car_floor[1]),
      .seg_n   (seg_n),
      .an_n    (an_n)
   );

   // R8
   local_rst_a_chk: assert property (@(posedge clk) disable iff (rst)
      rst_a && !rst_b |=> floor_a == 4'd2 && floor_b != 4'd0);
   // R9
   master_rst_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> floor_a == 4'd2 && floor_b == 4'd2 && !step_led);

endmodule

// File: tb/dual_lift_ctrl_tb.sv
`timescale 1ns/100ps
module dual_lift_ctrl_tb_top;
   localparam int TICK = 8;
   localparam int SCAN = 3;

   logic clk = 1'b0;
   logic rst = 1'b1, rst_a = 1'b0, rst_b = 1'b0;
   logic stop_a = 1'b1, dir_a = 1'b1, stop_b = 1'b1, dir_b = 1'b0;
   logic [6:0] seg_n;
   logic [3:0] an_n;
   logic       step_led;
   logic [3:0] floor_a, floor_b;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   dual_lift_ctrl #(.TICK_CYCLES(TICK), .SCAN_CYCLES(SCAN)) dut_i (
      .clk(clk), .rst(rst), .rst_a(rst_a), .rst_b(rst_b),
      .stop_a(stop_a), .dir_a(dir_a), .stop_b(stop_b), .dir_b(dir_b),
      .seg_n(seg_n), .an_n(an_n), .step_led(step_led),
      .floor_a(floor_a), .floor_b(floor_b)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [6:0] exp_seg(input int f);
      case (f)
         1: return ~7'b0000110;
         2: return ~7'b1011011;
         3: return ~7'b1001111;
         4: return ~7'b1100110;
         5: return ~7'b1101101;
         6: return ~7'b1111101;
         7: return ~7'b0000111;
         8: return ~7'b1111111;
         9: return ~7'b1101111;
         default: return 7'h7F;
      endcase
   endfunction

   task automatic wait_step(output int n);
      logic prev;
      prev = step_led;
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (step_led == prev && n < 4 * TICK);
   endtask

   task automatic t_reset();
      rst = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1 floor_a in reset", floor_a, 2);
      chk("R1 floor_b in reset", floor_b, 2);
      rst = 1'b0;
      @(negedge clk);
      chk("R1 floor_a after release", floor_a, 2);
      chk("R1 floor_b after release", floor_b, 2);
      chk("R1 step_led", step_led, 0);
      chk("R1 an_n", an_n, 4'b1110);
   endtask

   task automatic t_timing_and_hold();
      int n;
      wait_step(n);
      chk("R9 first step after release", n, TICK - 1);
      wait_step(n);
      chk("R2 step interval", n, TICK);
      chk("R5 car A held", floor_a, 2);
      chk("R5 car B held", floor_b, 2);
   endtask

   task automatic t_travel();
      int n;
      stop_a = 1'b0; dir_a = 1'b1;
      stop_b = 1'b0; dir_b = 1'b0;
      wait_step(n);
      chk("R3 car A up", floor_a, 3);
      chk("R4 car B down", floor_b, 1);
      for (int f = 4; f <= 9; f++) begin
         wait_step(n);
         chk("R3 car A climbing", floor_a, f);
         chk("R7 car B at bottom", floor_b, 1);
      end
      wait_step(n);
      chk("R6 car A at top", floor_a, 9);
      chk("R2 interval while moving", n, TICK);
      dir_a = 1'b0;
      wait_step(n);
      chk("R4 car A down", floor_a, 8);
   endtask

   task automatic t_local_reset();
      int n;
      stop_a = 1'b1; stop_b = 1'b1;
      repeat (2) @(negedge clk);
      rst_a = 1'b1;
      @(negedge clk);
      rst_a = 1'b0;
      chk("R8 car A reset", floor_a, 2);
      chk("R8 car B kept", floor_b, 1);
      wait_step(n);
      chk("R8 divider untouched", n, TICK - 3);
      rst_b = 1'b1;
      @(negedge clk);
      rst_b = 1'b0;
      chk("R8 car B reset", floor_b, 2);
      chk("R8 car A kept", floor_a, 2);
      stop_b = 1'b0; dir_b = 1'b0;
      wait_step(n);
      chk("R4 car B after reset", floor_b, 1);
      stop_b = 1'b1;
   endtask

   task automatic t_display(input int fa, input int fb);
      int run, cur, prev_d, seen;
      run = 0; prev_d = -1; seen = 0;
      for (int i = 0; i < 10 * SCAN; i++) begin
         @(negedge clk);
         cur = -1;
         for (int d = 0; d < 4; d++) if (an_n == ~(4'b1 << d)) cur = d;
         if (cur < 0) chk("R11 one digit low", an_n, 4'b1110);
         else begin
            if (cur == 2)      chk("R10 digit 2 shows car A", seg_n, exp_seg(fa));
            else if (cur == 0) chk("R10 digit 0 shows car B", seg_n, exp_seg(fb));
            else               chk("R10 blank digit", seg_n, 7'h7F);
            if (cur == prev_d) run++;
            else begin
               if (prev_d >= 0) begin
                  chk("R11 scan order", cur, (prev_d + 1) % 4);
                  if (seen > 0) chk("R11 dwell", run, SCAN);
                  seen++;
               end
               run = 1;
            end
            prev_d = cur;
         end
      end
   endtask

   task automatic t_master_reset();
      int n;
      stop_a = 1'b0; dir_a = 1'b1;
      wait_step(n);
      chk("R3 car A up again", floor_a, 3);
      repeat (3) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk("R9 car A home", floor_a, 2);
      chk("R9 car B home", floor_b, 2);
      wait_step(n);
      chk("R9 divider restarted", n, TICK);
      chk("R3 car A after reset", floor_a, 3);
   endtask

   initial begin
      t_reset();
      t_timing_and_hold();
      t_travel();
      t_local_reset();
      t_display(2, 1);
      t_master_reset();
      stop_a = 1'b1;
      t_display(3, 2);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule